// File: doc/BRIEF.md
# Handshaked Subtractive GCD Unit

This block finds the greatest common divisor of two unsigned integers by Euclid's method in its subtractive form. Each compute cycle does one of three things. If the first register holds the smaller value, the two registers trade contents. If the second register is nonzero, the first register is reduced by the second. If the second register is zero, the work is finished and the first register holds the answer.

Operand pairs enter through a valid/ready handshake. The answer leaves through a second valid/ready handshake, so a slow consumer can hold the result for as long as it needs. Internally a three-state controller (idle, compute, result) drives the register enables and the multiplexer selects of a small datapath. That datapath has two registers, a subtractor, a less-than compare and a zero test. Only one operand pair is in flight at a time.

Top module: `gcd_euclid_unit`

## Requirements
- R1: After reset the unit is idle: `in_ready` is 1 and `out_valid` is 0.
- R2: `in_ready` is 1 only while idle. An operand pair is captured on a rising edge where `in_valid` and `in_ready` are both 1, and `in_ready` is 0 on the following cycle.
- R3: In a compute cycle where the first register is less than the second, the two registers exchange values.
- R4: In a compute cycle where the first register is not less than the second and the second is nonzero, the first register takes the difference and the second keeps its value. Counting the swap and subtract steps as k, `out_valid` rises k+1 cycles after the capture edge.
- R5: A compute cycle that finds the second register at zero ends the computation. `out_gcd` then equals the greatest common divisor of the captured operands.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_gcd` does not change. On an edge with both at 1 the unit returns to idle.
- R7: Zero operands: if both are zero the result is 0. If only the first is zero the result is the second operand, after one swap step.
- R8: `in_valid` and the operand buses have no effect while the unit is computing or presenting a result.
- R9: `in_ready` and `out_valid` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Unit can take an operand pair |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_gcd | output | WIDTH | Greatest common divisor |

## Verification
The case hardest to reach from the ports is a new operand pair arriving while an earlier one is still being reduced or is still waiting on the consumer. The bench sweeps every operand pair of a 4-bit instance. On alternate pairs it keeps `in_valid` high with unrelated operands for the whole busy period, and on some pairs it holds `out_ready` low for several cycles. Both the result and the exact latency are then compared against values worked out arithmetically in the bench.

// File: rtl/gcd_euclid_unit.sv
module gcd_euclid_unit #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_gcd
);

  typedef enum logic [1:0] {S_IDLE, S_CALC, S_DONE} state_t;
  typedef enum logic [1:0] {AS_IN, AS_SWAP, AS_DIFF} asel_t;
  typedef enum logic       {BS_IN, BS_SWAP} bsel_t;

  state_t state_q, state_d;
  asel_t  a_sel;
  bsel_t  b_sel;
  logic   a_en, b_en;
  logic [WIDTH-1:0] a_q, b_q, a_nxt, b_nxt, diff;
  logic   a_lt_b, b_is_zero;

  assign diff      = a_q - b_q;
  assign a_lt_b    = a_q < b_q;
  assign b_is_zero = b_q == '0;

  always_comb begin
    case (a_sel)
      AS_SWAP: a_nxt = b_q;
      AS_DIFF: a_nxt = diff;
      default: a_nxt = in_a;
    endcase
  end

  assign b_nxt = (b_sel == BS_SWAP) ? a_q : in_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (a_en) a_q <= a_nxt;
      if (b_en) b_q <= b_nxt;
    end
  end

  always_comb begin
    state_d = state_q;
    a_sel   = AS_IN;
    b_sel   = BS_IN;
    a_en    = 1'b0;
    b_en    = 1'b0;
    case (state_q)
      S_IDLE: if (in_valid) begin
        a_en    = 1'b1;
        b_en    = 1'b1;
        state_d = S_CALC;
      end
      S_CALC: if (a_lt_b) begin
        a_sel = AS_SWAP;
        b_sel = BS_SWAP;
        a_en  = 1'b1;
        b_en  = 1'b1;
      end else if (!b_is_zero) begin
        a_sel = AS_DIFF;
        a_en  = 1'b1;
      end else begin
        state_d = S_DONE;
      end
      S_DONE: if (out_ready) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign in_ready  = state_q == S_IDLE;
  assign out_valid = state_q == S_DONE;
  assign out_gcd   = a_q;

endmodule

// File: rtl/gcd_euclid_unit_chk.sv
module gcd_euclid_unit_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_gcd,
  input logic [WIDTH-1:0] a_q,
  input logic [WIDTH-1:0] b_q
);

  logic busy;
  assign busy = !in_ready && !out_valid;

  AST_READY_VALID_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R9

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready); // R2

  AST_SWAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (a_q < b_q) |=> a_q == $past(b_q) && b_q == $past(a_q)); // R3

  AST_SUB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (a_q >= b_q) && (b_q != '0) |=> a_q == $past(a_q - b_q) && $stable(b_q)); // R4

  AST_DONE_B_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> b_q == '0); // R5

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_gcd)); // R6

  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> in_ready); // R6

endmodule

bind gcd_euclid_unit gcd_euclid_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_gcd(out_gcd),
  .a_q(a_q), .b_q(b_q)
);

// File: tb/sim_gcd_euclid_unit.sv
`timescale 1ns/1ps
module sim_gcd_euclid_unit;
  localparam int W = 4;
  localparam int LIM = 4 * (1 << W) + 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic in_ready, out_valid;
  logic [W-1:0] out_gcd;
  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  gcd_euclid_unit #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_gcd(out_gcd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_gcd(input int x, input int y);
    int t;
    while (y != 0) begin t = x % y; x = y; y = t; end
    return x;
  endfunction

  function automatic int ref_steps(input int x, input int y);
    int n = 0;
    int t;
    while (y != 0 || x < y) begin
      if (x < y) begin t = x; x = y; y = t; end
      else x = x - y;
      n++;
    end
    return n;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run_pair(input int a, input int b, input bit junk, input int hold);
    int n;
    int w;
    string tg;
    tg = (a == 0 || b == 0) ? "R7" : (a < b) ? "R3/R5" : "R4/R5";
    @(negedge clk);
    in_a = a[W-1:0]; in_b = b[W-1:0]; in_valid = 1'b1;
    w = 0;
    while (!in_ready && w < LIM) begin @(negedge clk); w++; end
    chk(in_ready, "R2 ready when idle", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    // R8: keep offering unrelated operands while busy
    if (junk) begin in_a = ~a[W-1:0]; in_b = a[W-1:0] ^ 4'h5; in_valid = 1'b1; end
    else in_valid = 1'b0;
    chk(!in_ready, "R2 ready drops after capture", in_ready, 0);
    n = 0;
    while (!out_valid && n < LIM) begin
      @(negedge clk); n++;
      chk(!(in_ready && out_valid), "R9", in_ready, 0);
    end
    chk(n == ref_steps(a, b) + 1, {tg, " latency"}, n, ref_steps(a, b) + 1);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(out_valid && out_gcd == ref_gcd(a, b), "R6 hold", out_gcd, ref_gcd(a, b));
    end
    chk(out_gcd == ref_gcd(a, b), {tg, " result"}, out_gcd, ref_gcd(a, b));
    if (junk) chk(out_gcd == ref_gcd(a, b), "R8 ignored operands", out_gcd, ref_gcd(a, b));
    out_ready = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    out_ready = 1'b0;
    chk(in_ready && !out_valid, "R6 back to idle", in_ready, 1);
  endtask

  initial begin
    #1;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset state", {in_ready, out_valid}, 2);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 after reset", {in_ready, out_valid}, 2);
    run_pair(0, 0, 0, 0);   // R7
    run_pair(0, 9, 1, 2);   // R7 single swap
    run_pair(12, 8, 0, 3);  // R4
    run_pair(3, 15, 1, 0);  // R3
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        run_pair(a, b, (a ^ b) & 1, ((a + b) % 5 == 0) ? 3 : 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule